// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Bank

This block collects up to 32 single-cycle event pulses from neighbouring logic into sticky pending bits and folds them into one level-sensitive interrupt line. Each pending bit stays set until software clears it. A mask bit for each source decides whether that pending bit may drive the line. Pending bits may be set while masked, and they stay visible to software.

Software reaches the bank through a plain register port: valid, write, byte address and data. Reads return one cycle later with a response strobe. Pending bits and mask bits are each changed only through paired write-one-to-set and write-one-to-clear registers. Zero bits in the write data never disturb state, so several agents can share the bank without read-modify-write sequences. A typical handler reads the pending word, clears the bits it will service and masks the same bits. When it has finished, it unmasks them again.

Top module: `irq_bank_top`

## Requirements
- R1: After reset all pending bits are 0, all mask bits are 1 and irq_o is low.
- R2: A pulse on evt_i[i] sets pending bit i on that clock edge, and the bit stays set with no further pulse until it is cleared.
- R3: irq_o is high exactly when some pending bit is 1 and its mask bit is 0.
- R4: A write to byte offset 0x08 clears exactly the pending bits given as ones in the data. All other bits keep their value.
- R5: A write to byte offset 0x04 sets exactly the pending bits given as ones in the data, so a test interrupt can be raised.
- R6: A write to offset 0x10 sets exactly the mask bits given as ones in the data. A write to offset 0x14 clears exactly the mask bits given as ones in the data.
- R7: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: A read of offset 0x00 returns the raw pending word regardless of mask. A read of offset 0x0C returns the mask word.
- R9: A read request gives rsp_valid high in the next cycle only, with data that reflects state before the request edge. rsp_rdata is zero whenever rsp_valid is low.
- R10: Writes to 0x00, 0x0C or any other unlisted offset change no state. Reads of 0x04, 0x08, 0x10, 0x14 or unlisted offsets return zero.
- R11: Writing all ones to offset 0x10 and then all ones to offset 0x08 leaves irq_o low.
- R12: Source i always lands in pending bit i. The fixed assignments are bit 4 link up, bit 5 link down, bit 13 receive DMA done, bit 16 transmit DMA done, bit 23 management done and bit 24 management error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | Single-cycle event pulses, one per source |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | NSRC | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | NSRC | Read data |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The assertions assume that evt_i is synchronous to clk and is sampled as a pulse, with no meaning attached to how long it is held. They also assume that at most one register access arrives per cycle, so a set and a clear of the same word can never meet in one cycle. The bench drives every input half a cycle away from the sampling edge and issues at most one request per cycle. It makes events sparse by ANDing several random words, so pending bits both build up and get cleared. Random addresses include an unaligned one and one past the map, so the ignore rules are exercised as well.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int unsigned REG_AW = 8;

  // byte offsets of the register port
  localparam logic [REG_AW-1:0] OFS_PEND      = 8'h00;
  localparam logic [REG_AW-1:0] OFS_PEND_SET  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_PEND_CLR  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_MASK      = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_MASK_SET  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_MASK_CLR  = 8'h14;

  // fixed source positions
  localparam int unsigned SRC_LINK_UP   = 4;
  localparam int unsigned SRC_LINK_DOWN = 5;
  localparam int unsigned SRC_RX_DONE   = 13;
  localparam int unsigned SRC_TX_DONE   = 16;
  localparam int unsigned SRC_MGMT_DONE = 23;
  localparam int unsigned SRC_MGMT_ERR  = 24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_PEND_SET,
    SEL_PEND_CLR,
    SEL_MASK,
    SEL_MASK_SET,
    SEL_MASK_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_PEND:     s = SEL_PEND;
      OFS_PEND_SET: s = SEL_PEND_SET;
      OFS_PEND_CLR: s = SEL_PEND_CLR;
      OFS_MASK:     s = SEL_MASK;
      OFS_MASK_SET: s = SEL_MASK_SET;
      OFS_MASK_CLR: s = SEL_MASK_CLR;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_bank_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [REG_AW-1:0]   req_addr,
  input  logic [NSRC-1:0]     req_wdata,
  output logic [NSRC-1:0]     pend_set_o,
  output logic [NSRC-1:0]     pend_clr_o,
  output logic [NSRC-1:0]     mask_set_o,
  output logic [NSRC-1:0]     mask_clr_o,
  output logic                rd_req_o,
  output reg_sel_e            rd_sel_o
);

  reg_sel_e sel;
  logic     wr_go;

  assign sel   = decode_offset(req_addr);
  assign wr_go = req_valid && req_write;

  // write strobes carry the data bits only when their register is hit
  assign pend_set_o = (wr_go && sel == SEL_PEND_SET) ? req_wdata : '0;
  assign pend_clr_o = (wr_go && sel == SEL_PEND_CLR) ? req_wdata : '0;
  assign mask_set_o = (wr_go && sel == SEL_MASK_SET) ? req_wdata : '0;
  assign mask_clr_o = (wr_go && sel == SEL_MASK_CLR) ? req_wdata : '0;

  assign rd_req_o = req_valid && !req_write;
  assign rd_sel_o = sel;

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] pend_set_i,
  input  logic [NSRC-1:0] pend_clr_i,
  input  logic [NSRC-1:0] mask_set_i,
  input  logic [NSRC-1:0] mask_clr_i,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q
);

  // event and set dominate clear
  function automatic logic pend_next(input logic cur, input logic ev,
                                     input logic st, input logic cl);
    return ev | st | (cur & ~cl);
  endfunction

  function automatic logic mask_next(input logic cur, input logic st,
                                     input logic cl);
    return st | (cur & ~cl);
  endfunction

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b1;
      end else begin
        pend_q[i] <= pend_next(pend_q[i], evt_i[i], pend_set_i[i], pend_clr_i[i]);
        mask_q[i] <= mask_next(mask_q[i], mask_set_i[i], mask_clr_i[i]);
      end
    end
  end

  p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  p_evt_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & pend_clr_i)) |=>
      ((pend_q & $past(evt_i & pend_clr_i)) == $past(evt_i & pend_clr_i)));

  p_clear_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_clr_i) |=> ((pend_q & $past(pend_clr_i & ~evt_i)) == {NSRC{1'b0}}));

  p_set_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set_i) |=> ((pend_q & $past(pend_set_i)) == $past(pend_set_i)));

  p_mask_set_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_set_i) |=> ((mask_q & $past(mask_set_i)) == $past(mask_set_i)));

  p_mask_clr_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_clr_i) |=> ((mask_q & $past(mask_clr_i)) == {NSRC{1'b0}}));

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == {NSRC{1'b0}} && pend_set_i == {NSRC{1'b0}} &&
     pend_clr_i == {NSRC{1'b0}}) |=> (pend_q == $past(pend_q)));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set_i == {NSRC{1'b0}} && mask_clr_i == {NSRC{1'b0}})
      |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_bank_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req_i,
  input  reg_sel_e        rd_sel_i,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            rsp_valid_o,
  output logic [NSRC-1:0] rsp_rdata_o
);

  // only the two state words read back; write-only and unlisted read zero
  function automatic logic [NSRC-1:0] read_mux(input reg_sel_e s,
                                               input logic [NSRC-1:0] p,
                                               input logic [NSRC-1:0] m);
    logic [NSRC-1:0] r;
    case (s)
      SEL_PEND: r = p;
      SEL_MASK: r = m;
      default:  r = '0;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_req_i;
      rsp_rdata_o <= rd_req_i ? read_mux(rd_sel_i, pend_i, mask_i) : '0;
    end
  end

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rsp_valid_o);

  p_rsp_only_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rsp_valid_o);

  p_rdata_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (rsp_rdata_o == {NSRC{1'b0}}));

  p_pend_read_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && rd_sel_i == SEL_PEND) |=> (rsp_rdata_o == $past(pend_i)));

endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [NSRC-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [NSRC-1:0]   rsp_rdata,
  output logic              irq_o
);

  logic [NSRC-1:0] pend_set, pend_clr, mask_set, mask_clr;
  logic [NSRC-1:0] pend_q, mask_q;
  logic            rd_req;
  reg_sel_e        rd_sel;

  function automatic logic line_level(input logic [NSRC-1:0] p,
                                      input logic [NSRC-1:0] m);
    return |(p & ~m);
  endfunction

  irq_reg_decode #(.NSRC(NSRC)) u_decode (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .pend_set_o (pend_set),
    .pend_clr_o (pend_clr),
    .mask_set_o (mask_set),
    .mask_clr_o (mask_clr),
    .rd_req_o   (rd_req),
    .rd_sel_o   (rd_sel)
  );

  irq_state_bank #(.NSRC(NSRC)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .pend_set_i (pend_set),
    .pend_clr_i (pend_clr),
    .mask_set_i (mask_set),
    .mask_clr_i (mask_clr),
    .pend_q     (pend_q),
    .mask_q     (mask_q)
  );

  irq_readback #(.NSRC(NSRC)) u_readback (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req_i    (rd_req),
    .rd_sel_i    (rd_sel),
    .pend_i      (pend_q),
    .mask_i      (mask_q),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

  assign irq_o = line_level(pend_q, mask_q);

  p_all_masked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o);

  p_none_pending_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == {NSRC{1'b0}}) |-> !irq_o);

  p_unmasked_event_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ~mask_q & ~mask_set)) |=> irq_o);

endmodule

// File: tb/tb_irq_bank_top.sv
module tb_irq_bank_top;
  import irq_bank_pkg::*;

  localparam int unsigned NSRC = 32;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   evt_i = '0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [REG_AW-1:0] req_addr = '0;
  logic [NSRC-1:0]   req_wdata = '0;
  logic              rsp_valid;
  logic [NSRC-1:0]   rsp_rdata;
  logic              irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [NSRC-1:0] m_pend;
  logic [NSRC-1:0] m_mask;

  irq_bank_top #(.NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_line(input logic [NSRC-1:0] p, input logic [NSRC-1:0] m);
    logic r = 1'b0;
    for (int i = 0; i < NSRC; i++) if (p[i] && !m[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [NSRC-1:0] exp_read(input logic [7:0] a,
                                               input logic [NSRC-1:0] p,
                                               input logic [NSRC-1:0] m);
    if (a == 8'h00) return p;
    if (a == 8'h0C) return m;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus; model updated from the requirements; checks after the edge
  task automatic step(input string tag, input logic [NSRC-1:0] ev, input bit v,
                      input bit w, input logic [7:0] a, input logic [NSRC-1:0] d);
    logic [NSRC-1:0] rd_exp;
    bit rd;
    @(negedge clk);
    evt_i = ev; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    rd = v && !w;
    rd_exp = rd ? exp_read(a, m_pend, m_mask) : '0;
    if (v && w && a == 8'h04) m_pend = m_pend | d;
    if (v && w && a == 8'h08) m_pend = m_pend & ~d;
    m_pend = m_pend | ev;
    if (v && w && a == 8'h10) m_mask = m_mask | d;
    if (v && w && a == 8'h14) m_mask = m_mask & ~d;
    @(posedge clk); #1;
    evt_i = '0; req_valid = 1'b0; req_write = 1'b0;
    chk({tag, " R9 rsp_valid"}, {{(NSRC-1){1'b0}}, rsp_valid}, {{(NSRC-1){1'b0}}, rd});
    chk({tag, " R8/R9 rdata"}, rsp_rdata, rd_exp);
    chk({tag, " R3 irq"}, {{(NSRC-1){1'b0}}, irq_o}, {{(NSRC-1){1'b0}}, exp_line(m_pend, m_mask)});
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [NSRC-1:0] d);
    step(tag, '0, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    step(tag, '0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] addrs [8];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h02};
    void'($urandom(32'h5eed_1234));
    m_pend = '0;
    m_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 irq after reset", {{(NSRC-1){1'b0}}, irq_o}, '0);
    rd("R1 pending after reset", 8'h00);
    rd("R1 mask after reset", 8'h0C);

    // R2 / R3: masked event latches but the line stays low
    step("R2 masked event", 32'h0000_2000, 1'b0, 1'b0, 8'h00, '0);
    rd("R2 sticky raw read", 8'h00);
    // R6: unmask bit 13 raises the line
    wr("R6 mask clear", 8'h14, 32'h0000_2000);
    rd("R6 mask read", 8'h0C);
    // R4: clear exactly that bit
    wr("R4 clear", 8'h08, 32'h0000_2000);
    // R5: software set
    wr("R5 set", 8'h04, 32'h0000_2010);
    rd("R5 read", 8'h00);
    wr("R6 mask set", 8'h10, 32'h0000_2000);
    // R7: event and clear on the same bit
    step("R7 event vs clear", 32'h0000_0010, 1'b1, 1'b1, 8'h08, 32'h0000_0010);
    rd("R7 read", 8'h00);
    // R10: writes to read-only and unlisted offsets ignored; reads of write-only give zero
    wr("R10 write to pending", 8'h00, 32'hFFFF_FFFF);
    wr("R10 write to mask status", 8'h0C, 32'h0000_0000);
    wr("R10 write unlisted", 8'h18, 32'hFFFF_FFFF);
    wr("R10 write unaligned", 8'h09, 32'hFFFF_FFFF);
    rd("R10 pending unchanged", 8'h00);
    rd("R10 mask unchanged", 8'h0C);
    rd("R10 read set reg", 8'h04);
    rd("R10 read unlisted", 8'h1C);
    // R12: fixed positions
    wr("R12 unmask all", 8'h14, 32'hFFFF_FFFF);
    wr("R12 clear", 8'h08, 32'hFFFF_FFFF);
    step("R12 link up", 32'h1 << SRC_LINK_UP, 1'b0, 1'b0, 8'h00, '0);
    step("R12 link down", 32'h1 << SRC_LINK_DOWN, 1'b0, 1'b0, 8'h00, '0);
    step("R12 rx done", 32'h1 << SRC_RX_DONE, 1'b0, 1'b0, 8'h00, '0);
    step("R12 tx done", 32'h1 << SRC_TX_DONE, 1'b0, 1'b0, 8'h00, '0);
    step("R12 mgmt", (32'h1 << SRC_MGMT_DONE) | (32'h1 << SRC_MGMT_ERR), 1'b0, 1'b0, 8'h00, '0);
    rd("R12 positions", 8'h00);
    // R11: init sequence leaves the line low
    wr("R11 mask all", 8'h10, 32'hFFFF_FFFF);
    wr("R11 clear all", 8'h08, 32'hFFFF_FFFF);
    chk("R11 line low", {{(NSRC-1){1'b0}}, irq_o}, '0);

    // constrained random: sparse events, one access per cycle
    for (int n = 0; n < 4000; n++) begin
      logic [NSRC-1:0] ev, d;
      logic [7:0] a;
      bit v, w;
      ev = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom & $urandom) : '0;
      v  = ($urandom % 3) != 0;
      w  = ($urandom % 2) != 0;
      a  = addrs[$urandom % 8];
      d  = ($urandom % 8 == 0) ? '1 : ($urandom & $urandom);
      step("R2-mix random", ev, v, w, a, d);
    end

    report();
  end

endmodule